// File: doc/BRIEF.md
# Write-Protect State Manager for a Serial EEPROM

This block sits next to the serial-bus controller of a 256-byte EEPROM and decides, for every byte of a command, whether the device acknowledges it. It holds two protection flags. One is a reversible soft flag and the other a permanent flag, and either one shields the lower half of the array, addresses 00h to 7Fh. It also recognises the commands that change those flags. They arrive with their own device-type code and are honoured only while the A0 pin carries the high-voltage level.

The bus controller presents each received byte with a one-cycle strobe. These are the slave byte, the most significant bit of the word address, and each data byte. A stop strobe marks the end of the command. The block answers each strobe with a registered acknowledge decision and a memory write enable. On stop it may start an internal write cycle of `CYCLE_TICKS` clocks. Flag changes take effect only when that cycle runs to the end. If the write-protect pin goes high during the cycle, the cycle is abandoned and the flags are left as they were. The stored flag values survive a reset through two preload inputs.

Top module: `prot_guard`

## Requirements
- R1: The slave byte is split as bits [7:4] type, [3:1] select and bit 0 direction (1 = read). A memory command has type 1010 and a select equal to `devPins`. When the block is idle it is acknowledged one clock after `cmdStrobe`. Any other memory select is not acknowledged.
- R2: A protect command has type 0110 and direction 0, and it needs `a0HighVolt` high. Its select is 001 for set-soft, 011 for clear-soft and 000 for permanent set. Any other select, a read direction, or a low `a0HighVolt` gets no acknowledge.
- R3: While `cycleBusy` is high, no slave byte is acknowledged and no new write cycle starts, so the command is cancelled.
- R4: When `wpPin` is high at a data byte, that byte is not acknowledged and `memWrite` stays low. When `wpPin` is high at stop, no write cycle starts.
- R5: When either flag is set, a memory write with address MSB 0 acknowledges the slave and address bytes but not the data byte, and no cycle runs. With address MSB 1 it acknowledges all bytes and pulses `memWrite`.
- R6: When the permanent flag is set, every protect command is refused at the slave, address and data phases.
- R7: When only the soft flag is set, a set-soft command is refused at every phase. Clear-soft and permanent set are acknowledged at every phase and start a cycle.
- R8: With no flag set and `wpPin` low, protect commands and memory writes are acknowledged at every phase. A stop after an accepted data byte raises `cycleBusy` for exactly `CYCLE_TICKS` clocks. The flag change is visible on the clock after `cycleBusy` falls, and not earlier.
- R9: `wpPin` high during a write cycle, including on its final clock, ends the cycle on the next clock and leaves both flags unchanged.
- R10: During reset the soft and permanent flags load from `presetSoft` and `presetPerm`. After reset all acknowledges, `memWrite` and `cycleBusy` are low.
- R11: Once the permanent flag is set it never clears. A clear-soft command sent afterwards changes nothing.
- R12: The address byte of a read command and any data byte that follows it are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presetSoft | input | 1 | Stored soft-flag value loaded during reset |
| presetPerm | input | 1 | Stored permanent-flag value loaded during reset |
| devPins | input | 3 | Device select strapping |
| a0HighVolt | input | 1 | A0 pin is at the high-voltage level |
| wpPin | input | 1 | Write-protect pin level |
| cmdStrobe | input | 1 | Slave byte received |
| cmdByte | input | 8 | Received slave byte |
| addrStrobe | input | 1 | Word address byte received |
| wordAddrMsb | input | 1 | Bit 7 of the target word address |
| dataStrobe | input | 1 | Data byte received |
| stopStrobe | input | 1 | Stop condition seen |
| ackCmd | output | 1 | Acknowledge decision for the slave byte |
| ackAddr | output | 1 | Acknowledge decision for the address byte |
| ackData | output | 1 | Acknowledge decision for the latest data byte |
| memWrite | output | 1 | One-clock write enable for the array |
| cycleBusy | output | 1 | Internal write cycle in progress |
| softProt | output | 1 | Soft protection flag |
| permProt | output | 1 | Permanent protection flag |

## Verification
Two events can land on the same clock: the write cycle reaching its last tick, which would commit a flag change, and the write-protect pin rising, which aborts the cycle. The bench starts a set-soft cycle and raises `wpPin` exactly in the cycle's final clock. It then expects `cycleBusy` to drop with the soft flag still clear, which shows that the abort takes priority over the commit. A second run raises the pin in the middle of the cycle and expects the same outcome.

// File: rtl/prot_guard_pkg.sv
package prot_guard_pkg;
  localparam logic [3:0] MEM_TYPE  = 4'b1010;
  localparam logic [3:0] PROT_TYPE = 4'b0110;
  localparam logic [2:0] SEL_SET   = 3'b001;
  localparam logic [2:0] SEL_CLR   = 3'b011;
  localparam logic [2:0] SEL_PERM  = 3'b000;

  typedef enum logic [2:0] {
    K_NONE, K_MEMWR, K_MEMRD, K_SET, K_CLR, K_PERM
  } cmdKind_e;

  typedef enum logic [1:0] {
    OP_NONE, OP_SET, OP_CLR, OP_PERM
  } flagOp_e;

  typedef struct packed {
    logic    start;
    flagOp_e op;
    logic    abort;
  } ctrlStrobe_t;
endpackage

// File: rtl/prot_guard_ctrl.sv
module prot_guard_ctrl
  import prot_guard_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  devPins,
  input  logic        a0HighVolt,
  input  logic        wpPin,
  input  logic        cmdStrobe,
  input  logic [7:0]  cmdByte,
  input  logic        addrStrobe,
  input  logic        wordAddrMsb,
  input  logic        dataStrobe,
  input  logic        stopStrobe,
  input  logic        busy,
  input  logic        softFlag,
  input  logic        permFlag,
  output ctrlStrobe_t strobe,
  output logic        ackCmd,
  output logic        ackAddr,
  output logic        ackData,
  output logic        memWrite
);
  cmdKind_e decKind, kind;
  logic     isProt, cmdOk, dataOk, lowCovered, armed, addrHigh;
  flagOp_e  pendOp;

  // slave byte decode
  always_comb begin
    decKind = K_NONE;
    if (cmdByte[7:4] == MEM_TYPE && cmdByte[3:1] == devPins)
      decKind = cmdByte[0] ? K_MEMRD : K_MEMWR;
    else if (cmdByte[7:4] == PROT_TYPE && a0HighVolt && !cmdByte[0]) begin
      case (cmdByte[3:1])
        SEL_SET:  decKind = K_SET;
        SEL_CLR:  decKind = K_CLR;
        SEL_PERM: decKind = K_PERM;
        default:  decKind = K_NONE;
      endcase
    end
  end

  assign isProt = (decKind == K_SET) || (decKind == K_CLR) || (decKind == K_PERM);
  assign cmdOk  = !busy && (decKind != K_NONE)
                  && !(isProt && permFlag)
                  && !(decKind == K_SET && softFlag);

  assign lowCovered = !addrHigh && (softFlag || permFlag);
  assign dataOk     = ackAddr && !wpPin && !(kind == K_MEMWR && lowCovered);

  always_comb begin
    case (kind)
      K_SET:   pendOp = OP_SET;
      K_CLR:   pendOp = OP_CLR;
      K_PERM:  pendOp = OP_PERM;
      default: pendOp = OP_NONE;
    endcase
  end

  assign strobe.start = stopStrobe && armed && !wpPin && !busy;
  assign strobe.op    = pendOp;
  assign strobe.abort = busy && wpPin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind     <= K_NONE;
      ackCmd   <= 1'b0;
      ackAddr  <= 1'b0;
      ackData  <= 1'b0;
      memWrite <= 1'b0;
      armed    <= 1'b0;
      addrHigh <= 1'b0;
    end else begin
      memWrite <= 1'b0;
      if (cmdStrobe) begin
        kind    <= decKind;
        ackCmd  <= cmdOk;
        ackAddr <= 1'b0;
        ackData <= 1'b0;
        armed   <= 1'b0;
      end else if (addrStrobe) begin
        ackAddr  <= ackCmd && (kind != K_MEMRD);
        addrHigh <= wordAddrMsb;
        ackData  <= 1'b0;
      end else if (dataStrobe) begin
        ackData  <= dataOk;
        memWrite <= dataOk && (kind == K_MEMWR);
        if (dataOk) armed <= 1'b1;
      end else if (stopStrobe) begin
        kind    <= K_NONE;
        armed   <= 1'b0;
        ackCmd  <= 1'b0;
        ackAddr <= 1'b0;
        ackData <= 1'b0;
      end
    end
  end

  assert_busy_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdStrobe && busy) |=> !ackCmd);

  assert_wp_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dataStrobe && wpPin) |=> (!ackData && !memWrite));

  assert_perm_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdStrobe && cmdByte[7:4] == PROT_TYPE && permFlag) |=> !ackCmd);
endmodule

// File: rtl/prot_guard_dp.sv
module prot_guard_dp
  import prot_guard_pkg::*;
#(
  parameter int CYCLE_TICKS = 625000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        presetSoft,
  input  logic        presetPerm,
  input  ctrlStrobe_t strobe,
  output logic        busy,
  output logic        softProt,
  output logic        permProt
);
  localparam int CW = $clog2(CYCLE_TICKS + 1);

  logic [CW-1:0] cnt;
  flagOp_e       heldOp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      heldOp   <= OP_NONE;
      softProt <= presetSoft;
      permProt <= presetPerm;
    end else if (!busy) begin
      if (strobe.start) begin
        busy   <= 1'b1;
        cnt    <= CW'(CYCLE_TICKS - 1);
        heldOp <= strobe.op;
      end
    end else if (strobe.abort) begin
      busy <= 1'b0;
    end else if (cnt == '0) begin
      busy <= 1'b0;
      case (heldOp)
        OP_SET:  softProt <= 1'b1;
        OP_CLR:  softProt <= 1'b0;
        OP_PERM: permProt <= 1'b1;
        default: ;
      endcase
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assert_perm_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    permProt |=> permProt);

  assert_flags_at_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({softProt, permProt}) |-> $past(busy));

  assert_abort_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && strobe.abort) |=> (!busy && $stable({softProt, permProt})));

  assert_start_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.start |-> !busy);
endmodule

// File: rtl/prot_guard.sv
module prot_guard
  import prot_guard_pkg::*;
#(
  parameter int CYCLE_TICKS = 625000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       presetSoft,
  input  logic       presetPerm,
  input  logic [2:0] devPins,
  input  logic       a0HighVolt,
  input  logic       wpPin,
  input  logic       cmdStrobe,
  input  logic [7:0] cmdByte,
  input  logic       addrStrobe,
  input  logic       wordAddrMsb,
  input  logic       dataStrobe,
  input  logic       stopStrobe,
  output logic       ackCmd,
  output logic       ackAddr,
  output logic       ackData,
  output logic       memWrite,
  output logic       cycleBusy,
  output logic       softProt,
  output logic       permProt
);
  ctrlStrobe_t strobe;

  prot_guard_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .devPins(devPins), .a0HighVolt(a0HighVolt),
    .wpPin(wpPin), .cmdStrobe(cmdStrobe), .cmdByte(cmdByte),
    .addrStrobe(addrStrobe), .wordAddrMsb(wordAddrMsb),
    .dataStrobe(dataStrobe), .stopStrobe(stopStrobe), .busy(cycleBusy),
    .softFlag(softProt), .permFlag(permProt), .strobe(strobe),
    .ackCmd(ackCmd), .ackAddr(ackAddr), .ackData(ackData), .memWrite(memWrite)
  );

  prot_guard_dp #(.CYCLE_TICKS(CYCLE_TICKS)) u_dp (
    .clk(clk), .rst_n(rst_n), .presetSoft(presetSoft), .presetPerm(presetPerm),
    .strobe(strobe), .busy(cycleBusy), .softProt(softProt), .permProt(permProt)
  );
endmodule

// File: tb/prot_guard_bench.sv
`timescale 1ns/1ps
module prot_guard_bench;
  localparam int TICKS = 20;
  localparam int NVEC  = 17;

  logic clk = 1'b0, rst_n = 1'b0;
  logic presetSoft = 1'b0, presetPerm = 1'b0;
  logic [2:0] devPins = 3'b101;
  logic a0HighVolt = 1'b1, wpPin = 1'b0;
  logic cmdStrobe = 1'b0, addrStrobe = 1'b0, dataStrobe = 1'b0, stopStrobe = 1'b0;
  logic [7:0] cmdByte = 8'h00;
  logic wordAddrMsb = 1'b0;
  logic ackCmd, ackAddr, ackData, memWrite, cycleBusy, softProt, permProt;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  prot_guard #(.CYCLE_TICKS(TICKS)) u_prot_guard (
    .clk(clk), .rst_n(rst_n), .presetSoft(presetSoft), .presetPerm(presetPerm),
    .devPins(devPins), .a0HighVolt(a0HighVolt), .wpPin(wpPin),
    .cmdStrobe(cmdStrobe), .cmdByte(cmdByte), .addrStrobe(addrStrobe),
    .wordAddrMsb(wordAddrMsb), .dataStrobe(dataStrobe), .stopStrobe(stopStrobe),
    .ackCmd(ackCmd), .ackAddr(ackAddr), .ackData(ackData), .memWrite(memWrite),
    .cycleBusy(cycleBusy), .softProt(softProt), .permProt(permProt)
  );

  // {slave, addrMsb(bit7 of byte), wp, cmd, addr, data, cycle, soft, perm}
  localparam logic [22:0] VEC [NVEC] = '{
    {8'hAA, 8'h10, 1'b0, 6'b111100},
    {8'hA0, 8'h10, 1'b0, 6'b000000},
    {8'hAA, 8'h10, 1'b1, 6'b110000},
    {8'h62, 8'h00, 1'b1, 6'b110000},
    {8'h62, 8'h00, 1'b0, 6'b111110},
    {8'hAA, 8'h10, 1'b0, 6'b110010},
    {8'hAA, 8'h90, 1'b0, 6'b111110},
    {8'h62, 8'h00, 1'b0, 6'b000010},
    {8'h66, 8'h00, 1'b0, 6'b111100},
    {8'hAA, 8'h10, 1'b0, 6'b111100},
    {8'h63, 8'h00, 1'b0, 6'b000000},
    {8'hAB, 8'h00, 1'b0, 6'b100000},
    {8'h60, 8'h00, 1'b0, 6'b111101},
    {8'h66, 8'h00, 1'b0, 6'b000001},
    {8'h62, 8'h00, 1'b0, 6'b000001},
    {8'hAA, 8'h10, 1'b0, 6'b110001},
    {8'hAA, 8'hF0, 1'b0, 6'b111101}
  };

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 100 && cycleBusy; i++) @(negedge clk);
  endtask

  task automatic doReset(input logic ps, input logic pp);
    presetSoft = ps; presetPerm = pp; wpPin = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one transaction: slave byte, address, data, stop
  task automatic txn(input logic [22:0] v, input int idx);
    string tag;
    tag = $sformatf("vec%0d", idx);
    wpPin = v[6];
    cmdByte = v[22:15];
    pulse(cmdStrobe);
    chk("R1 R2 R6 R7", {tag, " ackCmd"}, ackCmd, v[5]);
    wordAddrMsb = v[14];
    pulse(addrStrobe);
    chk("R5 R12", {tag, " ackAddr"}, ackAddr, v[4]);
    pulse(dataStrobe);
    chk("R4 R5 R8", {tag, " ackData"}, ackData, v[3]);
    pulse(stopStrobe);
    chk("R4 R8", {tag, " cycleBusy"}, cycleBusy, v[2]);
    waitIdle();
    wpPin = 1'b0;
    @(negedge clk);
    chk("R7 R8 R11", {tag, " softProt"}, softProt, v[1]);
    chk("R6 R11", {tag, " permProt"}, permProt, v[0]);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset(1'b0, 1'b0);
    // R10 reset state
    chk("R10", "ackCmd", ackCmd, 1'b0);
    chk("R10", "cycleBusy", cycleBusy, 1'b0);
    chk("R10", "softProt", softProt, 1'b0);
    chk("R10", "permProt", permProt, 1'b0);

    for (int i = 0; i < NVEC; i++) txn(VEC[i], i);

    // R2: protect command without high voltage on A0
    doReset(1'b0, 1'b0);
    a0HighVolt = 1'b0;
    cmdByte = 8'h62;
    pulse(cmdStrobe);
    chk("R2", "ackCmd no HV", ackCmd, 1'b0);
    pulse(stopStrobe);
    a0HighVolt = 1'b1;
    // R2: unknown protect select 111
    cmdByte = 8'h6E;
    pulse(cmdStrobe);
    chk("R2", "ackCmd bad select", ackCmd, 1'b0);
    pulse(stopStrobe);

    // R8 exact cycle length, R3 command cancelled while busy
    cmdByte = 8'hAA; wordAddrMsb = 1'b0;
    pulse(cmdStrobe); pulse(addrStrobe); pulse(dataStrobe);
    chk("R8", "memWrite pulse", memWrite, 1'b1);
    pulse(stopStrobe);
    chk("R8", "busy after stop", cycleBusy, 1'b1);
    cmdByte = 8'h62;
    pulse(cmdStrobe);
    chk("R3", "ackCmd while busy", ackCmd, 1'b0);
    pulse(addrStrobe); pulse(dataStrobe);
    chk("R3", "ackData while busy", ackData, 1'b0);
    pulse(stopStrobe);
    repeat (TICKS - 5) @(negedge clk);
    chk("R8", "busy on last tick", cycleBusy, 1'b1);
    @(negedge clk);
    chk("R8", "busy ends", cycleBusy, 1'b0);
    chk("R3", "cancelled set left soft", softProt, 1'b0);

    // R9 abort on the final clock, coinciding with commit
    cmdByte = 8'h62;
    pulse(cmdStrobe); pulse(addrStrobe); pulse(dataStrobe); pulse(stopStrobe);
    repeat (TICKS - 1) @(negedge clk);
    chk("R9", "busy before final tick", cycleBusy, 1'b1);
    wpPin = 1'b1;
    @(negedge clk);
    wpPin = 1'b0;
    chk("R9", "busy after final abort", cycleBusy, 1'b0);
    chk("R9", "soft unchanged after final abort", softProt, 1'b0);

    // R9 abort mid-cycle
    cmdByte = 8'h60;
    pulse(cmdStrobe); pulse(addrStrobe); pulse(dataStrobe); pulse(stopStrobe);
    repeat (5) @(negedge clk);
    wpPin = 1'b1;
    @(negedge clk);
    wpPin = 1'b0;
    chk("R9", "busy after mid abort", cycleBusy, 1'b0);
    repeat (TICKS) @(negedge clk);
    chk("R9", "perm unchanged after mid abort", permProt, 1'b0);

    // R4 WP rises between data byte and stop
    cmdByte = 8'hAA; wordAddrMsb = 1'b1;
    pulse(cmdStrobe); pulse(addrStrobe); pulse(dataStrobe);
    chk("R4", "data ack with wp low", ackData, 1'b1);
    wpPin = 1'b1;
    pulse(stopStrobe);
    chk("R4", "no cycle with wp at stop", cycleBusy, 1'b0);
    wpPin = 1'b0;

    // R10 preload of stored flags
    doReset(1'b1, 1'b0);
    chk("R10", "preset soft", softProt, 1'b1);
    cmdByte = 8'hAA; wordAddrMsb = 1'b0;
    pulse(cmdStrobe); pulse(addrStrobe); pulse(dataStrobe);
    chk("R5 R10", "preset soft guards low half", ackData, 1'b0);
    pulse(stopStrobe);
    doReset(1'b0, 1'b1);
    chk("R10", "preset perm", permProt, 1'b1);
    cmdByte = 8'h66;
    pulse(cmdStrobe);
    chk("R6 R11", "clear refused under preset perm", ackCmd, 1'b0);
    pulse(stopStrobe);
    repeat (TICKS + 2) @(negedge clk);
    chk("R11", "perm stays", permProt, 1'b1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule